// File: doc/BRIEF.md
# Coherent Line Invalidation Sequencer

This block controls one cache line of a coherent requester. When software or a higher-level agent asks for the line to be invalidated, the block does not send the invalidating request straight away. It first brings the line's tracked coherence state to Invalid, and only then sends the MakeInvalid transaction on its outgoing port.

How the line gets to Invalid depends on its current state:

- A clean line (Shared Clean, Unique Clean or Unique Clean Exclusive) is dropped to Invalid silently.
- A Unique Dirty line is never dropped directly. The block sends a WriteBack first and waits for it to complete. It then records the line as Unique Clean, drops it to Invalid, and sends the MakeInvalid.
- A line that is already Invalid goes straight to the MakeInvalid.

The user asks only for the invalidation. The write-back step is added by the block without any extra request.

The line state is sampled from `lineStateIn` when a request is accepted. The block reports the state it tracks on `lineState` throughout the sequence. Outgoing transactions use a valid/ready handshake, and each one waits for its own completion strobe. A one-cycle `done` pulse ends the sequence. `illegalIssue` rises if a MakeInvalid is ever presented while the tracked state is not Invalid.

Top module: `lineInvalSequencer`

## Requirements
- R1: After reset, `lineState` is I (0), `txValid` is 0, `done` is 0 and `reqReady` is 1.
- R2: A MakeInvalid issue (`txValid`=1, `txType`=2) is only presented while `lineState` is I. State codes are I=0, SC=1, UC=2, UCE=3, UD=4.
- R3: A request on a line in SC, UC or UCE sends no WriteBack. In the cycle after acceptance, `lineState` shows the sampled state and `txValid` is 0. In the next cycle `lineState` is I and the MakeInvalid is presented.
- R4: A request on a UD line presents a WriteBack (`txType`=1) in the cycle after acceptance, with `lineState` UD. The line stays UD until that WriteBack completes.
- R5: In the cycle after `wbComp`, `lineState` is UC and `txValid` is 0. In the following cycle `lineState` is I and the MakeInvalid is presented.
- R6: A request on a line already in I presents the MakeInvalid in the cycle after acceptance.
- R7: A presented transaction keeps `txValid` high and `txType` unchanged until `txReady` is seen. After acceptance, `txValid` is 0 until the next issue.
- R8: `reqReady` is 0 from the cycle after acceptance until the cycle after `done`. A request offered while busy is ignored.
- R9: In the cycle after `miComp` is seen, while waiting for the MakeInvalid, `done` is 1 for exactly one cycle with `lineState` I. In the next cycle `reqReady` is 1.
- R10: A completion strobe, or `txReady`, arriving when it is not awaited has no effect on `lineState`, `txValid` or `done`.
- R11: `illegalIssue` is never 1 during correct sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request to invalidate the line |
| reqReady | output | 1 | High when a request can be accepted |
| lineStateIn | input | 3 | Current line state, sampled on acceptance |
| txValid | output | 1 | Outgoing transaction presented |
| txReady | input | 1 | Outgoing transaction accepted |
| txType | output | 2 | 0 none, 1 WriteBack, 2 MakeInvalid |
| wbComp | input | 1 | WriteBack completion strobe |
| miComp | input | 1 | MakeInvalid completion strobe |
| lineState | output | 3 | Tracked line state |
| done | output | 1 | One-cycle end-of-sequence pulse |
| illegalIssue | output | 1 | MakeInvalid presented while state is not I |

## Verification
The assertions assume that each completion strobe is a single-cycle pulse and that the fabric raises it only after the matching transaction has been accepted. The stimulus follows this: it pulses a completion exactly once, after the handshake for that transaction.

Stray completions and stray `txReady` are injected only to show that they are ignored, and only in phases where the design does not wait for them. The sampled line state is always one of the five legal codes. Ready stalls and completion delays are varied, and requests are offered during busy periods.

// File: rtl/invalSeqPkg.sv
package invalSeqPkg;
  localparam int STATE_W  = 3;
  localparam int TXTYPE_W = 2;
  localparam int PHASE_W  = 3;

  typedef enum logic [STATE_W-1:0] {
    LS_I   = 3'd0,
    LS_SC  = 3'd1,
    LS_UC  = 3'd2,
    LS_UCE = 3'd3,
    LS_UD  = 3'd4
  } lineState_e;

  typedef enum logic [TXTYPE_W-1:0] {
    TX_NONE      = 2'd0,
    TX_WRITEBACK = 2'd1,
    TX_MAKEINVAL = 2'd2
  } txType_e;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE, PH_WB_ISSUE, PH_WB_WAIT, PH_DROP,
    PH_MI_ISSUE, PH_MI_WAIT, PH_DONE
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic markClean;
    logic markInvalid;
    logic issueWb;
    logic issueMi;
  } ctrlStrobe_t;

  // datapath -> control classification of the sampled state
  typedef struct packed {
    logic inDirty;
    logic inInvalid;
  } lineClass_t;
endpackage

// File: rtl/invalSeqData.sv
module invalSeqData
  import invalSeqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [STATE_W-1:0]  lineStateIn,
  output lineClass_t          lineClass,
  output logic [STATE_W-1:0]  lineState,
  output logic                txValid,
  output logic [TXTYPE_W-1:0] txType,
  output logic                illegalIssue
);
  logic [STATE_W-1:0] stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= LS_I;
    end else if (strobe.capture) begin
      stateQ <= lineStateIn;
    end else if (strobe.markInvalid) begin
      stateQ <= LS_I;
    end else if (strobe.markClean) begin
      stateQ <= LS_UC;
    end
  end

  always_comb begin
    lineClass.inDirty   = (lineStateIn == LS_UD);
    lineClass.inInvalid = (lineStateIn == LS_I);
  end

  always_comb begin
    txValid = strobe.issueWb | strobe.issueMi;
    if (strobe.issueMi) begin
      txType = TX_MAKEINVAL;
    end else if (strobe.issueWb) begin
      txType = TX_WRITEBACK;
    end else begin
      txType = TX_NONE;
    end
  end

  assign lineState    = stateQ;
  assign illegalIssue = strobe.issueMi && (stateQ != LS_I);

  // R2: MakeInvalid strobe from control only while the line is already Invalid
  p_mi_only_in_i_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueMi |-> stateQ == LS_I);

  // R4: a dirty line never falls straight to Invalid
  p_ud_no_direct_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == LS_UD |=> (stateQ == LS_UD || stateQ == LS_UC));

  // R5: a line reaches UC only from a dirty line
  p_uc_from_ud_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == LS_UD && !strobe.capture) ##1 stateQ == LS_UC |-> $past(strobe.markClean));
endmodule

// File: rtl/invalSeqCtrl.sv
module invalSeqCtrl
  import invalSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  lineClass_t  lineClass,
  input  logic        txReady,
  input  logic        wbComp,
  input  logic        miComp,
  output logic        reqReady,
  output logic        done,
  output ctrlStrobe_t strobe
);
  phase_e phaseQ, phaseD;
  logic   accept;

  assign reqReady = (phaseQ == PH_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_IDLE: begin
        if (accept) begin
          if (lineClass.inDirty) begin
            phaseD = PH_WB_ISSUE;
          end else if (lineClass.inInvalid) begin
            phaseD = PH_MI_ISSUE;
          end else begin
            phaseD = PH_DROP;
          end
        end
      end
      PH_WB_ISSUE: if (txReady) phaseD = PH_WB_WAIT;
      PH_WB_WAIT:  if (wbComp)  phaseD = PH_DROP;
      PH_DROP:     phaseD = PH_MI_ISSUE;
      PH_MI_ISSUE: if (txReady) phaseD = PH_MI_WAIT;
      PH_MI_WAIT:  if (miComp)  phaseD = PH_DONE;
      PH_DONE:     phaseD = PH_IDLE;
      default:     phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
    end else begin
      phaseQ <= phaseD;
    end
  end

  always_comb begin
    strobe.capture     = accept;
    strobe.markClean   = (phaseQ == PH_WB_WAIT) && wbComp;
    strobe.markInvalid = (phaseQ == PH_DROP);
    strobe.issueWb     = (phaseQ == PH_WB_ISSUE);
    strobe.issueMi     = (phaseQ == PH_MI_ISSUE);
  end

  assign done = (phaseQ == PH_DONE);

  // R7: an issue strobe stays up until the handshake completes
  p_hold_wb_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueWb && !txReady |=> strobe.issueWb);
  p_hold_mi_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueMi && !txReady |=> strobe.issueMi);

  // R8: once a request is taken, no further request is taken next cycle
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R9: done is a single pulse followed by readiness
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);
endmodule

// File: rtl/lineInvalSequencer.sv
module lineInvalSequencer
  import invalSeqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [STATE_W-1:0]  lineStateIn,
  output logic                txValid,
  input  logic                txReady,
  output logic [TXTYPE_W-1:0] txType,
  input  logic                wbComp,
  input  logic                miComp,
  output logic [STATE_W-1:0]  lineState,
  output logic                done,
  output logic                illegalIssue
);
  ctrlStrobe_t strobe;
  lineClass_t  lineClass;

  invalSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lineClass (lineClass),
    .txReady   (txReady),
    .wbComp    (wbComp),
    .miComp    (miComp),
    .reqReady  (reqReady),
    .done      (done),
    .strobe    (strobe)
  );

  invalSeqData uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lineStateIn  (lineStateIn),
    .lineClass    (lineClass),
    .lineState    (lineState),
    .txValid      (txValid),
    .txType       (txType),
    .illegalIssue (illegalIssue)
  );

  // R7: presented transaction type does not change while stalled
  p_tx_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txType));

  // R11: the illegal-issue flag never rises
  p_no_illegal_r11: assert property (@(posedge clk) disable iff (!rstN)
    !illegalIssue);
endmodule

// File: tb/lineInvalSequencer_test.sv
`timescale 1ns/1ps
module lineInvalSequencer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [2:0] lineStateIn = 3'd0;
  logic       txValid;
  logic       txReady = 1'b0;
  logic [1:0] txType;
  logic       wbComp = 1'b0;
  logic       miComp = 1'b0;
  logic [2:0] lineState;
  logic       done;
  logic       illegalIssue;

  int checks = 0;
  int fails = 0;
  int illegalSeen = 0;
  bit finished = 1'b0;

  localparam logic [2:0] S_I = 3'd0, S_SC = 3'd1, S_UC = 3'd2, S_UCE = 3'd3, S_UD = 3'd4;
  localparam logic [1:0] T_WB = 2'd1, T_MI = 2'd2;
  localparam int NVEC = 10;
  // {state[2:0], readyStall[1:0], compDelay[1:0], stray}
  localparam logic [7:0] VEC [NVEC] = '{
    {S_I,   2'd0, 2'd0, 1'b0},
    {S_SC,  2'd1, 2'd2, 1'b1},
    {S_UC,  2'd0, 2'd1, 1'b0},
    {S_UCE, 2'd3, 2'd0, 1'b1},
    {S_UD,  2'd0, 2'd0, 1'b0},
    {S_UD,  2'd2, 2'd3, 1'b1},
    {S_UD,  2'd1, 2'd0, 1'b0},
    {S_SC,  2'd0, 2'd0, 1'b0},
    {S_I,   2'd2, 2'd1, 1'b1},
    {S_UCE, 2'd0, 2'd3, 1'b0}
  };

  always #4 clk = ~clk;

  lineInvalSequencer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .lineStateIn(lineStateIn), .txValid(txValid), .txReady(txReady),
    .txType(txType), .wbComp(wbComp), .miComp(miComp),
    .lineState(lineState), .done(done), .illegalIssue(illegalIssue)
  );

  always @(negedge clk) if (rstN && illegalIssue) illegalSeen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entered at a negedge where the issue is expected
  task automatic handshake(input logic [1:0] expType, input int stall, input logic [2:0] expState);
    chk(txValid && txType == expType, "R7 issue type", txType, expType);
    chk(lineState == expState, "R2/R4 state at issue", lineState, expState);
    for (int i = 0; i < stall; i++) begin
      reqValid = 1'b1;
      lineStateIn = S_UD;
      @(negedge clk);
      chk(txValid && txType == expType, "R7 held while stalled", txType, expType);
      chk(!reqReady, "R8 busy ready low", reqReady, 0);
    end
    reqValid = 1'b0;
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    chk(!txValid, "R7 valid drops after accept", txValid, 0);
  endtask

  // entered at a negedge in the wait phase; returns one negedge after completion edge
  task automatic complete(input bit isWb, input int dly, input bit stray, input logic [2:0] holdState);
    for (int i = 0; i < dly; i++) begin
      if (stray && i == 0) begin
        if (isWb) miComp = 1'b1; else wbComp = 1'b1;
      end
      @(negedge clk);
      miComp = 1'b0;
      wbComp = 1'b0;
      chk(!txValid && !done && lineState == holdState, "R10 wrong completion ignored", lineState, holdState);
    end
    if (isWb) wbComp = 1'b1; else miComp = 1'b1;
    @(negedge clk);
    wbComp = 1'b0;
    miComp = 1'b0;
  endtask

  task automatic runSeq(input logic [2:0] st, input int stall, input int dly, input bit stray);
    chk(reqReady, "R8 ready before request", reqReady, 1);
    reqValid = 1'b1;
    lineStateIn = st;
    @(negedge clk);
    reqValid = 1'b0;
    lineStateIn = S_UD;
    chk(!reqReady, "R8 ready low after accept", reqReady, 0);
    if (st == S_UD) begin
      handshake(T_WB, stall, S_UD);                     // R4
      complete(1'b1, dly, stray, S_UD);
      chk(lineState == S_UC && !txValid, "R5 clean after writeback", lineState, S_UC);
      @(negedge clk);
      handshake(T_MI, stall, S_I);                      // R5, R2
    end else if (st == S_I) begin
      handshake(T_MI, stall, S_I);                      // R6
    end else begin
      chk(lineState == st && !txValid, "R3 sampled state before drop", lineState, st);
      @(negedge clk);
      handshake(T_MI, stall, S_I);                      // R3
    end
    complete(1'b0, dly, stray, S_I);
    chk(done && lineState == S_I, "R9 done with line invalid", done, 1);
    chk(!reqReady, "R8 ready low during done", reqReady, 0);
    @(negedge clk);
    chk(!done && reqReady, "R9 single pulse then ready", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lineState == S_I, "R1 reset lineState", lineState, S_I);
    chk(!txValid && !done, "R1 reset no issue", txValid, 0);
    chk(reqReady, "R1 reset ready", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      runSeq(VEC[v][7:5], int'(VEC[v][4:3]), int'(VEC[v][2:1]), VEC[v][0]);
    end

    // R10: stray handshake inputs while idle
    wbComp = 1'b1; miComp = 1'b1; txReady = 1'b1;
    @(negedge clk);
    wbComp = 1'b0; miComp = 1'b0; txReady = 1'b0;
    @(negedge clk);
    chk(!txValid && !done && lineState == S_I && reqReady, "R10 idle strays ignored", lineState, S_I);

    // R8: request while busy in drop phase is not taken
    reqValid = 1'b1; lineStateIn = S_SC;
    @(negedge clk);
    lineStateIn = S_UD;   // still offered during the drop cycle
    chk(lineState == S_SC, "R8 busy request ignored", lineState, S_SC);
    @(negedge clk);
    reqValid = 1'b0;
    chk(lineState == S_I && txType == T_MI, "R8 sequence undisturbed", lineState, S_I);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    complete(1'b0, 0, 1'b0, S_I);
    chk(done, "R9 done after busy request", done, 1);
    @(negedge clk);

    chk(illegalSeen == 0, "R11 illegal flag never set", illegalSeen, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule